// File: doc/BRIEF.md
# Timer Input Capture Unit

This block sits beside a free-running 16-bit timer counter. It watches one of four input pins and latches the counter value into a capture register when a chosen transition appears on that pin. The block can also ask the counter to restart from its load value on each capture. It keeps a sticky edge flag, and that flag drives an interrupt line and a DMA request line, each behind its own enable. The counter itself lives outside the block: the block only reads the count and returns a one-cycle reload request.

The selected pin passes through an optional inversion stage and one sampling register. It then goes through a digital filter and reaches an edge detector. The filter is a two-state machine. In STABLE the filtered level is settled. A tick whose sample differs from the filtered level moves it to QUALIFY (STABLE→QUALIFY). In QUALIFY, each further disagreeing tick adds to a run counter. An agreeing tick sends it back (QUALIFY→STABLE, rejected). The level is taken over once the run reaches the required length (QUALIFY→STABLE, accepted). When the period setting is zero, the filter is bypassed and the sampled level goes straight through. The flag is a second two-state machine. A capture moves it from IDLE to PENDING (IDLE→PENDING). A clear pulse in a cycle with no capture moves it back (PENDING→IDLE). A capture while the flag is PENDING keeps it there.

Top module: `ic_capture_unit`

## Requirements
- R1: `cap_mode_i` selects the capture condition on the filtered, polarity-adjusted level: 0 never captures, 1 captures on a low-to-high change, 2 on a high-to-low change, 3 on either change.
- R2: With `invert_i` at 1 the pin level is inverted before filtering, so code 1 captures falling pin edges and code 2 captures rising pin edges.
- R3: `pin_sel_i` (value n) selects `pin_i[n]` as the capture source, and activity on the other pins has no effect.
- R4: A capture stores the value of `count_i` at the capturing clock edge. With the filter bypassed, a pin change set up before clock edge k is captured at edge k+2.
- R5: When `reload_en_i` is 1, each capture raises `reload_req_o` for exactly one cycle, starting in the cycle the capture appears. When `reload_en_i` is 0, `reload_req_o` stays 0.
- R6: A capture sets `edge_flag_o`. The flag stays set until a cycle where `flag_clr_i` is 1 and no capture occurs. A capture in the same cycle as a clear wins. A new capture while the flag is set overwrites `cap_val_o`.
- R7: `irq_o` is `edge_flag_o` gated by `irq_en_i`, and `dma_req_o` is `edge_flag_o` gated by `dma_en_i`.
- R8: With `filt_per_i` equal to 0, the filter adds exactly one register stage and passes every sampled level.
- R9: With `filt_per_i` = P > 0, the level is sampled every P clocks. A new level is taken only after `filt_cnt_i`+3 consecutive disagreeing samples, and a shorter disagreement is discarded.
- R10: During reset, `cap_val_o`, `edge_flag_o`, `reload_req_o`, `irq_o` and `dma_req_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | 4 | Channel input pins |
| pin_sel_i | input | 2 | Index of the capture source pin |
| invert_i | input | 1 | Invert the selected pin |
| cap_mode_i | input | 2 | Capture condition code (R1) |
| count_i | input | 16 | Current value of the external counter |
| reload_en_i | input | 1 | Request a counter reload on every capture |
| irq_en_i | input | 1 | Interrupt enable |
| dma_en_i | input | 1 | DMA request enable |
| filt_cnt_i | input | 3 | Filter run length minus 3 |
| filt_per_i | input | 8 | Filter sampling period in clocks; 0 bypasses the filter |
| flag_clr_i | input | 1 | Write-one clear of the edge flag |
| cap_val_o | output | 16 | Capture register |
| edge_flag_o | output | 1 | Sticky edge flag |
| reload_req_o | output | 1 | One-cycle counter reload request |
| irq_o | output | 1 | Interrupt request |
| dma_req_o | output | 1 | DMA request |

## Verification
The bench targets the two-cycle capture latency. A design that is off by one register would latch a count one away from the expected one. It also targets polarity inversion. A design that inverts after the edge detector, instead of before it, would capture on the wrong pin edge. Filter glitches shorter than the required run are driven, and a filter that counts non-consecutive samples or misses the +3 offset would pass them through as captures. Clears that collide with captures, overwrites while the flag is set, and noise on unselected pins expose a flag that drops a capture, a capture register that refuses to update, or a multiplexer that listens to the wrong pin.

// File: rtl/ic_pkg.sv
package ic_pkg;
    typedef enum logic [1:0] {
        CAP_OFF  = 2'd0,
        CAP_RISE = 2'd1,
        CAP_FALL = 2'd2,
        CAP_BOTH = 2'd3
    } cap_mode_e;

    typedef enum logic {
        FLT_STABLE  = 1'b0,
        FLT_QUALIFY = 1'b1
    } flt_state_e;

    typedef enum logic {
        FLG_IDLE    = 1'b0,
        FLG_PENDING = 1'b1
    } flg_state_e;
endpackage

// File: rtl/ic_pin_front.sv
module ic_pin_front #(
    parameter int NPIN  = 4,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPIN-1:0]  pin_i,
    input  logic [SEL_W-1:0] pin_sel_i,
    input  logic             invert_i,
    output logic             smp_o
);
    logic lvl;

    always_comb begin
        lvl = pin_i[pin_sel_i] ^ invert_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_o <= 1'b0;
        else        smp_o <= lvl;
    end
endmodule

// File: rtl/ic_glitch_filter.sv
module ic_glitch_filter
    import ic_pkg::*;
#(
    parameter int FCNT_W = 3,
    parameter int FPER_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_i,
    input  logic [FCNT_W-1:0] filt_cnt_i,
    input  logic [FPER_W-1:0] filt_per_i,
    output logic              filt_o
);
    localparam int AG_W = FCNT_W + 2;

    flt_state_e        st_q, st_d;
    logic [AG_W-1:0]   ag_q, ag_d, need;
    logic [FPER_W-1:0] per_q, per_d;
    logic              lvl_q, lvl_d;
    logic              bypass, tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= FLT_STABLE;
            ag_q  <= '0;
            per_q <= '0;
            lvl_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            ag_q  <= ag_d;
            per_q <= per_d;
            lvl_q <= lvl_d;
        end
    end

    always_comb begin
        need   = AG_W'(filt_cnt_i) + AG_W'(3);
        bypass = (filt_per_i == '0);
        tick   = !bypass && (per_q >= filt_per_i - FPER_W'(1));
        per_d  = (bypass || tick) ? '0 : per_q + FPER_W'(1);
        st_d   = st_q;
        ag_d   = ag_q;
        lvl_d  = lvl_q;
        if (bypass) begin
            st_d  = FLT_STABLE;
            ag_d  = '0;
            lvl_d = smp_i;
        end else if (tick) begin
            unique case (st_q)
                FLT_STABLE: begin
                    if (smp_i != lvl_q) begin
                        st_d = FLT_QUALIFY;
                        ag_d = AG_W'(1);
                    end
                end
                FLT_QUALIFY: begin
                    if (smp_i == lvl_q) begin
                        st_d = FLT_STABLE;
                        ag_d = '0;
                    end else if (ag_q + AG_W'(1) == need) begin
                        st_d  = FLT_STABLE;
                        ag_d  = '0;
                        lvl_d = smp_i;
                    end else begin
                        ag_d = ag_q + AG_W'(1);
                    end
                end
            endcase
        end
    end

    assign filt_o = lvl_q;
endmodule

// File: rtl/ic_edge_capture.sv
module ic_edge_capture
    import ic_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             filt_i,
    input  logic [1:0]       cap_mode_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             reload_en_i,
    input  logic             flag_clr_i,
    output logic [CNT_W-1:0] cap_val_o,
    output logic             edge_flag_o,
    output logic             reload_req_o
);
    flg_state_e flg_q, flg_d;
    logic       prev_q, rise, fall, evt;

    always_comb begin
        rise = filt_i & ~prev_q;
        fall = ~filt_i & prev_q;
        unique case (cap_mode_e'(cap_mode_i))
            CAP_OFF:  evt = 1'b0;
            CAP_RISE: evt = rise;
            CAP_FALL: evt = fall;
            CAP_BOTH: evt = rise | fall;
        endcase
    end

    always_comb begin
        flg_d = flg_q;
        unique case (flg_q)
            FLG_IDLE:    if (evt) flg_d = FLG_PENDING;
            FLG_PENDING: if (!evt && flag_clr_i) flg_d = FLG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= FLG_IDLE;
        else        flg_q <= flg_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q       <= 1'b0;
            cap_val_o    <= '0;
            reload_req_o <= 1'b0;
        end else begin
            prev_q       <= filt_i;
            reload_req_o <= evt & reload_en_i;
            if (evt) cap_val_o <= count_i;
        end
    end

    assign edge_flag_o = (flg_q == FLG_PENDING);
endmodule

// File: rtl/ic_capture_unit.sv
module ic_capture_unit #(
    parameter int CNT_W  = 16,
    parameter int NPIN   = 4,
    parameter int FCNT_W = 3,
    parameter int FPER_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NPIN-1:0]          pin_i,
    input  logic [$clog2(NPIN)-1:0]  pin_sel_i,
    input  logic                     invert_i,
    input  logic [1:0]               cap_mode_i,
    input  logic [CNT_W-1:0]         count_i,
    input  logic                     reload_en_i,
    input  logic                     irq_en_i,
    input  logic                     dma_en_i,
    input  logic [FCNT_W-1:0]        filt_cnt_i,
    input  logic [FPER_W-1:0]        filt_per_i,
    input  logic                     flag_clr_i,
    output logic [CNT_W-1:0]         cap_val_o,
    output logic                     edge_flag_o,
    output logic                     reload_req_o,
    output logic                     irq_o,
    output logic                     dma_req_o
);
    localparam int SEL_W = $clog2(NPIN);

    logic smp, filt;

    ic_pin_front #(.NPIN(NPIN), .SEL_W(SEL_W)) u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pin_i),
        .pin_sel_i (pin_sel_i),
        .invert_i  (invert_i),
        .smp_o     (smp)
    );

    ic_glitch_filter #(.FCNT_W(FCNT_W), .FPER_W(FPER_W)) u_filt (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_i      (smp),
        .filt_cnt_i (filt_cnt_i),
        .filt_per_i (filt_per_i),
        .filt_o     (filt)
    );

    ic_edge_capture #(.CNT_W(CNT_W)) u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .filt_i       (filt),
        .cap_mode_i   (cap_mode_i),
        .count_i      (count_i),
        .reload_en_i  (reload_en_i),
        .flag_clr_i   (flag_clr_i),
        .cap_val_o    (cap_val_o),
        .edge_flag_o  (edge_flag_o),
        .reload_req_o (reload_req_o)
    );

    assign irq_o     = edge_flag_o & irq_en_i;
    assign dma_req_o = edge_flag_o & dma_en_i;
endmodule

// File: rtl/ic_capture_unit_chk.sv
module ic_capture_unit_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       cap_mode_i,
    input logic             reload_en_i,
    input logic             irq_en_i,
    input logic             dma_en_i,
    input logic             flag_clr_i,
    input logic [CNT_W-1:0] cap_val_o,
    input logic             edge_flag_o,
    input logic             reload_req_o,
    input logic             irq_o,
    input logic             dma_req_o
);
    a_r1_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
        cap_mode_i == 2'd0 |=> $stable(cap_val_o));

    a_r6_capture_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_val_o) |-> edge_flag_o);

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        edge_flag_o && !flag_clr_i |=> edge_flag_o);

    a_r5_reload_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        reload_req_o |-> $past(reload_en_i) && edge_flag_o);

    a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> edge_flag_o && irq_en_i);

    a_r7_dma_gated: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_o |-> edge_flag_o && dma_en_i);
endmodule

bind ic_capture_unit ic_capture_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cap_mode_i   (cap_mode_i),
    .reload_en_i  (reload_en_i),
    .irq_en_i     (irq_en_i),
    .dma_en_i     (dma_en_i),
    .flag_clr_i   (flag_clr_i),
    .cap_val_o    (cap_val_o),
    .edge_flag_o  (edge_flag_o),
    .reload_req_o (reload_req_o),
    .irq_o        (irq_o),
    .dma_req_o    (dma_req_o)
);

// File: tb/ic_capture_unit_test.sv
module ic_capture_unit_test;
    localparam logic [15:0] LOAD_VAL = 16'h8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  pin_i = '0;
    logic [1:0]  pin_sel_i = '0;
    logic        invert_i = 1'b0;
    logic [1:0]  cap_mode_i = '0;
    logic [15:0] count_i = '0;
    logic        reload_en_i = 1'b0, irq_en_i = 1'b0, dma_en_i = 1'b0;
    logic [2:0]  filt_cnt_i = '0;
    logic [7:0]  filt_per_i = '0;
    logic        flag_clr_i = 1'b0;
    logic [15:0] cap_val_o;
    logic        edge_flag_o, reload_req_o, irq_o, dma_req_o;

    int    checks = 0, errors = 0;
    string tag = "R10";
    bit    cmp_on = 0;

    always #4 clk = ~clk;

    ic_capture_unit uut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // external counter stand-in
    always @(negedge clk) begin
        if (!rst_n) count_i <= '0;
        else        count_i <= reload_req_o ? LOAD_VAL : count_i + 16'd1;
    end

    // behavioural reference
    bit          m_smp, m_filt, m_prev, m_flag, m_reload;
    int          m_pc, m_agree;
    logic [15:0] m_cap;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_smp = 0; m_filt = 0; m_prev = 0; m_flag = 0; m_reload = 0;
            m_pc = 0; m_agree = 0; m_cap = '0;
        end else begin
            bit n_smp, n_filt, evt, rise, fall;
            int n_pc, n_ag;
            n_smp  = pin_i[pin_sel_i] ^ invert_i;
            n_filt = m_filt;
            n_pc   = m_pc;
            n_ag   = m_agree;
            if (filt_per_i == 0) begin
                n_filt = m_smp; n_pc = 0; n_ag = 0;
            end else if (m_pc >= int'(filt_per_i) - 1) begin
                n_pc = 0;
                if (m_smp != m_filt) begin
                    if (m_agree + 1 == int'(filt_cnt_i) + 3) begin
                        n_filt = m_smp; n_ag = 0;
                    end else n_ag = m_agree + 1;
                end else n_ag = 0;
            end else n_pc = (m_pc + 1) % 256;
            rise = m_filt && !m_prev;
            fall = !m_filt && m_prev;
            case (cap_mode_i)
                2'd1: evt = rise;
                2'd2: evt = fall;
                2'd3: evt = rise || fall;
                default: evt = 0;
            endcase
            if (evt) m_cap = count_i;
            m_reload = evt && reload_en_i;
            m_flag   = evt ? 1'b1 : (flag_clr_i ? 1'b0 : m_flag);
            m_prev   = m_filt;
            m_filt   = n_filt;
            m_smp    = n_smp;
            m_pc     = n_pc;
            m_agree  = n_ag;
        end
    end

    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            chk({tag, " cap_val"}, cap_val_o, m_cap);
            chk({tag, " flag"}, edge_flag_o, m_flag);
            chk({tag, " reload"}, reload_req_o, m_reload);
            chk({tag, " irq"}, irq_o, m_flag && irq_en_i);
            chk({tag, " dma"}, dma_req_o, m_flag && dma_en_i);
        end
    end

    task automatic step(int n = 1);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic pulse(int idx, int width);
        pin_i[idx] = 1'b1; step(width);
        pin_i[idx] = 1'b0; step(6);
    endtask

    task automatic clear_flag();
        flag_clr_i = 1'b1; step(1); flag_clr_i = 1'b0; step(1);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] exp_cnt, saved;
        step(3);
        // R10 reset state
        chk("R10 reset outputs", {cap_val_o, edge_flag_o, reload_req_o, irq_o, dma_req_o}, 0);
        rst_n = 1'b1; cmp_on = 1; step(3);

        // R4 latency with bypassed filter (R8)
        tag = "R4"; cap_mode_i = 2'd1;
        pin_i[0] = 1'b1; step(2);
        exp_cnt = count_i; step(1);
        chk("R4 captured count", cap_val_o, exp_cnt);
        chk("R8 bypass flag", edge_flag_o, 1);
        pin_i[0] = 1'b0; step(5); clear_flag();

        // R1 mode codes
        tag = "R1";
        cap_mode_i = 2'd2; pulse(0, 3);
        chk("R1 falling capture", edge_flag_o, 1); clear_flag();
        cap_mode_i = 2'd3; pulse(0, 4); pulse(0, 2);
        cap_mode_i = 2'd0; clear_flag(); saved = cap_val_o; pulse(0, 3);
        chk("R1 off keeps value", cap_val_o, saved);
        chk("R1 off keeps flag clear", edge_flag_o, 0);

        // R2 inversion
        tag = "R2"; invert_i = 1'b1; step(5); cap_mode_i = 2'd1;
        pin_i[0] = 1'b1; step(5);
        chk("R2 rising pin ignored in code 1", edge_flag_o, 0);
        pin_i[0] = 1'b0; step(5);
        chk("R2 falling pin captured in code 1", edge_flag_o, 1);
        cap_mode_i = 2'd0; invert_i = 1'b0; step(5); clear_flag();

        // R3 pin select
        tag = "R3"; pin_sel_i = 2'd2; cap_mode_i = 2'd3;
        pulse(0, 3); pulse(1, 3); pulse(3, 3);
        chk("R3 other pins ignored", edge_flag_o, 0);
        pulse(2, 3);
        chk("R3 selected pin captured", edge_flag_o, 1);

        // R6 overwrite while set, clear colliding with capture
        tag = "R6"; saved = cap_val_o; pulse(2, 5);
        chk("R6 overwrite while flag set", cap_val_o != saved, 1);
        flag_clr_i = 1'b1; pulse(2, 2); flag_clr_i = 1'b0; step(2);
        cap_mode_i = 2'd1; pin_i[2] = 1'b1; step(2); flag_clr_i = 1'b1; step(1);
        flag_clr_i = 1'b0; step(1);
        chk("R6 capture wins over clear", edge_flag_o, 1);
        pin_i[2] = 1'b0; step(4); clear_flag();

        // R7 request gating
        tag = "R7"; irq_en_i = 1'b1; dma_en_i = 1'b1; pulse(2, 3);
        chk("R7 irq asserted", irq_o, 1);
        chk("R7 dma asserted", dma_req_o, 1);
        irq_en_i = 1'b0; step(1);
        chk("R7 irq masked", irq_o, 0);
        dma_en_i = 1'b0; clear_flag();

        // R5 reload request
        tag = "R5"; reload_en_i = 1'b1; pulse(2, 3);
        chk("R5 counter reloaded", (count_i >= LOAD_VAL) && (count_i < LOAD_VAL + 16'd16), 1);
        reload_en_i = 1'b0; clear_flag();

        // R9 filter
        tag = "R9"; filt_per_i = 8'd2; filt_cnt_i = 3'd1; step(4);
        saved = cap_val_o; pulse(2, 3); step(10);
        chk("R9 short glitch rejected", edge_flag_o, 0);
        chk("R9 short glitch keeps value", cap_val_o, saved);
        pin_i[2] = 1'b1; step(20);
        chk("R9 long level accepted", edge_flag_o, 1);
        pin_i[2] = 1'b0; step(20); clear_flag();

        // mixed random traffic against the reference
        tag = "R9 random";
        for (int i = 0; i < 1500; i++) begin
            if (i % 300 == 0) begin
                filt_per_i = 8'($urandom_range(0, 3));
                filt_cnt_i = 3'($urandom_range(0, 2));
                cap_mode_i = 2'($urandom_range(0, 3));
                invert_i   = 1'($urandom_range(0, 1));
                reload_en_i = 1'($urandom_range(0, 1));
            end
            pin_i      = 4'($urandom);
            flag_clr_i = ($urandom_range(0, 7) == 0);
            irq_en_i   = 1'($urandom_range(0, 1));
            dma_en_i   = 1'($urandom_range(0, 1));
            step(1 + $urandom_range(0, 3));
        end
        finish_run();
    end
endmodule